// File: doc/BRIEF.md
# Rotating Register File

This block is a multi-ported register file for software-pipelined loops. The lowest register specifiers name fixed physical registers. The remaining specifiers name a rotating window. The physical slot in that window is the specifier's offset into the region plus a base value, reduced modulo the number of rotating registers. A loop-closing branch pulses `loopStep`, and the base then moves down by one. As a result, a value produced under logical name n in one iteration is found under logical name n+1 in the next iteration, and the loop body never has to be duplicated to rename registers.

The block has two combinational read ports and one synchronous write port. Each port takes a logical specifier. A write and a read that reach the same physical slot in the same cycle return the incoming data. `baseClear` returns the base to zero, for example at loop entry.

Top module: `rot_regfile`

## Requirements
- R1: After reset every register reads as zero on both read ports, and the rotation base is zero.
- R2: A specifier below NUM_STATIC (8) addresses the physical register with the same number, whatever the base is.
- R3: A specifier s at or above NUM_STATIC addresses physical register NUM_STATIC + ((s - NUM_STATIC + base) mod (NUM_REGS - NUM_STATIC)).
- R4: Each cycle with `loopStep` high and `baseClear` low lowers the base by one. Lowering a base of 0 gives NUM_REGS - NUM_STATIC - 1 (23).
- R5: Data written to rotating specifier n in a cycle with `loopStep` high reads back as specifier n+1 from the next cycle onward.
- R6: In the cycle `loopStep` is high, reads and the write use the old base. The new base applies from the following cycle.
- R7: `baseClear` sets the base to zero and takes priority over a coincident `loopStep`.
- R8: When a read port and the write port resolve to the same physical register in the same cycle with `wrEn` high, that read port returns `wrData`.
- R9: With `wrEn` low, no register changes, whatever `wrSpec` and `wrData` carry.
- R10: The two read ports resolve and return data independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| loopStep | input | 1 | Loop-closing branch strobe, lowers the base |
| baseClear | input | 1 | Returns the base to zero |
| wrEn | input | 1 | Write enable |
| wrSpec | input | 5 | Logical specifier for the write |
| wrData | input | 64 | Data to write |
| rdSpecA | input | 5 | Logical specifier, read port A |
| rdDataA | output | 64 | Read data, port A |
| rdSpecB | input | 5 | Logical specifier, read port B |
| rdDataB | output | 64 | Read data, port B |

## Verification
A write and a loop step can occur in the same cycle. The bench provokes this by writing a rotating specifier while pulsing `loopStep`. It then judges two results against its own arithmetic model of the base. First, a same-cycle read of that specifier must return the written data through the old mapping. Second, in the next cycle the data must be found under the specifier one higher. A clear and a step are also raised together, and the bench judges the resulting mapping by reading back every rotating specifier against a model base of zero.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
  // Per-cycle strobes from mapping control to storage
  typedef struct packed {
    logic wrEn;     // commit write this cycle
    logic bypassA;  // port A hits the slot being written
    logic bypassB;  // port B hits the slot being written
  } rrf_strobe_t;
endpackage

// File: rtl/rrf_ctrl.sv
module rrf_ctrl
  import rrf_pkg::*;
#(
  parameter int NUM_REGS   = 32,
  parameter int NUM_STATIC = 8,
  localparam int SPEC_W    = $clog2(NUM_REGS),
  localparam int ROT       = NUM_REGS - NUM_STATIC,
  localparam int BASE_W    = (ROT > 1) ? $clog2(ROT) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loopStep,
  input  logic              baseClear,
  input  logic              wrEn,
  input  logic [SPEC_W-1:0] wrSpec,
  input  logic [SPEC_W-1:0] rdSpecA,
  input  logic [SPEC_W-1:0] rdSpecB,
  output logic [SPEC_W-1:0] wrPhys,
  output logic [SPEC_W-1:0] rdPhysA,
  output logic [SPEC_W-1:0] rdPhysB,
  output rrf_strobe_t       strobes
);

  logic [BASE_W-1:0] baseQ;
  logic [BASE_W-1:0] baseNext;

  // Logical to physical: static region straight, rotating region offset
  function automatic logic [SPEC_W-1:0] mapSpec(input logic [SPEC_W-1:0] spec,
                                                 input logic [BASE_W-1:0] base);
    int off;
    if (int'(spec) < NUM_STATIC) begin
      return spec;
    end
    off = int'(spec) - NUM_STATIC + int'(base);
    if (off >= ROT) off = off - ROT;
    return SPEC_W'(NUM_STATIC + off);
  endfunction

  always_comb begin
    baseNext = baseQ;
    if (baseClear) begin
      baseNext = '0;
    end else if (loopStep) begin
      if (baseQ == '0) baseNext = BASE_W'(ROT - 1);
      else             baseNext = baseQ - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) baseQ <= '0;
    else       baseQ <= baseNext;
  end

  // All mappings use the current (old) base
  assign wrPhys  = mapSpec(wrSpec, baseQ);
  assign rdPhysA = mapSpec(rdSpecA, baseQ);
  assign rdPhysB = mapSpec(rdSpecB, baseQ);

  assign strobes.wrEn    = wrEn;
  assign strobes.bypassA = wrEn && (rdPhysA == wrPhys);
  assign strobes.bypassB = wrEn && (rdPhysB == wrPhys);

endmodule

// File: rtl/rrf_datapath.sv
module rrf_datapath
  import rrf_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 64,
  localparam int SPEC_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  rrf_strobe_t       strobes,
  input  logic [SPEC_W-1:0] wrPhys,
  input  logic [DATA_W-1:0] wrData,
  input  logic [SPEC_W-1:0] rdPhysA,
  input  logic [SPEC_W-1:0] rdPhysB,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB
);

  logic [DATA_W-1:0] regsQ [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        regsQ[g] <= '0;
      end else if (strobes.wrEn && (int'(wrPhys) == g)) begin
        regsQ[g] <= wrData;
      end
    end
  end

  // Write-first forwarding on each read port
  assign rdDataA = strobes.bypassA ? wrData : regsQ[rdPhysA];
  assign rdDataB = strobes.bypassB ? wrData : regsQ[rdPhysB];

endmodule

// File: rtl/rot_regfile.sv
module rot_regfile
  import rrf_pkg::*;
#(
  parameter int NUM_REGS   = 32,
  parameter int NUM_STATIC = 8,
  parameter int DATA_W     = 64,
  localparam int SPEC_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loopStep,
  input  logic              baseClear,
  input  logic              wrEn,
  input  logic [SPEC_W-1:0] wrSpec,
  input  logic [DATA_W-1:0] wrData,
  input  logic [SPEC_W-1:0] rdSpecA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [SPEC_W-1:0] rdSpecB,
  output logic [DATA_W-1:0] rdDataB
);

  logic [SPEC_W-1:0] wrPhys;
  logic [SPEC_W-1:0] rdPhysA;
  logic [SPEC_W-1:0] rdPhysB;
  rrf_strobe_t       strobes;

  rrf_ctrl #(.NUM_REGS(NUM_REGS), .NUM_STATIC(NUM_STATIC)) uCtrl (
    .clk(clk), .rstN(rstN), .loopStep(loopStep), .baseClear(baseClear),
    .wrEn(wrEn), .wrSpec(wrSpec), .rdSpecA(rdSpecA), .rdSpecB(rdSpecB),
    .wrPhys(wrPhys), .rdPhysA(rdPhysA), .rdPhysB(rdPhysB), .strobes(strobes)
  );

  rrf_datapath #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrPhys(wrPhys), .wrData(wrData),
    .rdPhysA(rdPhysA), .rdPhysB(rdPhysB), .rdDataA(rdDataA), .rdDataB(rdDataB)
  );

endmodule

// File: rtl/rot_regfile_chk.sv
module rot_regfile_chk #(
  parameter int NUM_REGS   = 32,
  parameter int NUM_STATIC = 8,
  parameter int DATA_W     = 64,
  localparam int SPEC_W    = $clog2(NUM_REGS)
) (
  input logic              clk,
  input logic              rstN,
  input logic              loopStep,
  input logic              baseClear,
  input logic              wrEn,
  input logic [SPEC_W-1:0] wrSpec,
  input logic [DATA_W-1:0] wrData,
  input logic [SPEC_W-1:0] rdSpecA,
  input logic [DATA_W-1:0] rdDataA,
  input logic [SPEC_W-1:0] rdSpecB,
  input logic [DATA_W-1:0] rdDataB
);

  // R1: first cycle out of reset, storage is zero
  a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(rstN) && !wrEn) |-> (rdDataA == '0 && rdDataB == '0));

  // R8: write-first forwarding, port A
  a_r8_bypass_a: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && rdSpecA == wrSpec) |-> rdDataA == wrData);

  // R8: write-first forwarding, port B
  a_r8_bypass_b: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && rdSpecB == wrSpec) |-> rdDataB == wrData);

  // R2: a static register keeps its value across any base movement
  a_r2_static_keep: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(wrEn) && int'($past(wrSpec)) < NUM_STATIC
      && rdSpecA == $past(wrSpec) && !wrEn) |-> rdDataA == $past(wrData));

  // R5: after one step, the value moves up one logical name
  a_r5_rename: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(wrEn) && $past(loopStep) && !$past(baseClear)
      && int'($past(wrSpec)) >= NUM_STATIC && int'($past(wrSpec)) < NUM_REGS - 1
      && int'(rdSpecA) == int'($past(wrSpec)) + 1 && !wrEn)
      |-> rdDataA == $past(wrData));

  // R9/R10 sanity: outputs never unknown once running
  a_r10_known: assert property (@(posedge clk) disable iff (!rstN)
    !$isunknown({rdDataA, rdDataB}));

endmodule

bind rot_regfile rot_regfile_chk #(
  .NUM_REGS(NUM_REGS), .NUM_STATIC(NUM_STATIC), .DATA_W(DATA_W)
) uChk (
  .clk(clk), .rstN(rstN), .loopStep(loopStep), .baseClear(baseClear),
  .wrEn(wrEn), .wrSpec(wrSpec), .wrData(wrData), .rdSpecA(rdSpecA),
  .rdDataA(rdDataA), .rdSpecB(rdSpecB), .rdDataB(rdDataB)
);

// File: tb/rot_regfile_test.sv
module rot_regfile_test;
  localparam int PERIOD  = 10;
  localparam int NREG    = 32;
  localparam int NSTAT   = 8;
  localparam int DW      = 64;
  localparam int NROT    = NREG - NSTAT;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          loopStep = 1'b0;
  logic          baseClear = 1'b0;
  logic          wrEn = 1'b0;
  logic [4:0]    wrSpec = '0;
  logic [DW-1:0] wrData = '0;
  logic [4:0]    rdSpecA = '0;
  logic [DW-1:0] rdDataA;
  logic [4:0]    rdSpecB = '0;
  logic [DW-1:0] rdDataB;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  int mBase = 0;
  logic [DW-1:0] model [NREG];

  always #(PERIOD/2) clk = ~clk;

  rot_regfile #(.NUM_REGS(NREG), .NUM_STATIC(NSTAT), .DATA_W(DW)) uut (
    .clk(clk), .rstN(rstN), .loopStep(loopStep), .baseClear(baseClear),
    .wrEn(wrEn), .wrSpec(wrSpec), .wrData(wrData), .rdSpecA(rdSpecA),
    .rdDataA(rdDataA), .rdSpecB(rdSpecB), .rdDataB(rdDataB)
  );

  function automatic int phys(input int s, input int b);
    if (s < NSTAT) return s;
    return NSTAT + ((s - NSTAT + b) % NROT);
  endfunction

  function automatic logic [DW-1:0] pat(input int it, input int s);
    return {16'hC0DE, 16'(it), 16'(s), 16'(it * 7 + s * 13)};
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Inputs change at negedge; outputs settle 1 time unit later
  task automatic drive(input bit we, input int ws, input logic [DW-1:0] wd,
                       input int ra, input int rb, input bit st, input bit cl);
    @(negedge clk);
    wrEn = we; wrSpec = 5'(ws); wrData = wd;
    rdSpecA = 5'(ra); rdSpecB = 5'(rb);
    loopStep = st; baseClear = cl;
    #1;
  endtask

  // Model update for what the next rising edge commits
  task automatic commit();
    if (wrEn) model[phys(int'(wrSpec), mBase)] = wrData;
    if (baseClear) mBase = 0;
    else if (loopStep) mBase = (mBase == 0) ? NROT - 1 : mBase - 1;
  endtask

  task automatic readAll(input string tagStatic, input string tagRot);
    for (int s = 0; s < NREG; s++) begin
      drive(1'b0, 0, '0, s, NREG - 1 - s, 1'b0, 1'b0);
      check(s < NSTAT ? tagStatic : tagRot, rdDataA, model[phys(s, mBase)]);
      check("R10", rdDataB, model[phys(NREG - 1 - s, mBase)]);
      commit();
    end
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset contents and base
    readAll("R1", "R1");

    // R2/R3/R4/R8/R10: sweep all bases plus wrap back to start
    for (int it = 0; it <= NROT; it++) begin
      for (int s = 0; s < NREG; s++) begin
        drive(1'b1, s, pat(it, s), s, s ^ 1, 1'b0, 1'b0);
        check("R8", rdDataA, pat(it, s));
        check("R10", rdDataB, model[phys(s ^ 1, mBase)]);
        commit();
      end
      readAll("R2", "R3");
      drive(1'b0, 0, '0, 0, 0, 1'b1, 1'b0);   // R4: step, wraps 0 -> 23
      commit();
    end

    // R5/R6: write under a step, same cycle sees old map, next cycle moves up
    drive(1'b1, 12, 64'h1234_5678_9ABC_DEF0, 12, 13, 1'b1, 1'b0);
    check("R6", rdDataA, 64'h1234_5678_9ABC_DEF0);
    check("R6", rdDataB, model[phys(13, mBase)]);
    commit();
    drive(1'b0, 0, '0, 13, 12, 1'b0, 1'b0);
    check("R5", rdDataA, 64'h1234_5678_9ABC_DEF0);
    check("R6", rdDataB, model[phys(12, mBase)]);
    commit();

    // R9: disabled write changes nothing
    drive(1'b0, 20, 64'hDEAD_BEEF_DEAD_BEEF, 20, 3, 1'b0, 1'b0);
    commit();
    drive(1'b0, 0, '0, 20, 3, 1'b0, 1'b0);
    check("R9", rdDataA, model[phys(20, mBase)]);
    check("R9", rdDataB, model[3]);
    commit();

    // R7: clear wins over a coincident step
    for (int k = 0; k < 5; k++) begin drive(1'b0, 0, '0, 0, 0, 1'b1, 1'b0); commit(); end
    drive(1'b0, 0, '0, 0, 0, 1'b1, 1'b1);
    commit();
    readAll("R7", "R7");

    drive(1'b0, 0, '0, 0, 0, 1'b0, 1'b0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule